// File: doc/BRIEF.md
# Cache Row Spare Steering and Half-Array Fold

This block sits in front of the row decoder of a cache data array that has a small set of spare rows and can run with one half of its rows switched off. For every access it turns the logical row index into the physical row to drive. The physical row is either the ordinary data row, or one of the spare rows when fuse information marks the row as defective. The configuration arrives on fuse-derived inputs. It gives a valid bit and a row index for each spare entry, a flag that switches the array to half capacity, and a bit that names the half that stays in service.

The fuse inputs are captured into registers in the first clock cycle after reset is released and are then held. Until that capture, the access row passes straight through. The steering itself is purely combinational from the access row to the physical row, so reads and writes see the same mapping with no added latency. In half-capacity mode the top index bit is replaced by the kept-half bit before the spare entries are compared. A defect can therefore be steered to a spare or removed by disabling its half, and both mechanisms can act together.

The physical row index is one bit wider than the logical row index. Values 0 to 2^ROW_W-1 are data rows, and value 2^ROW_W + k selects spare row k.

Top module: `cache_row_remap`

## Requirements
- R1: While reset is high, and until the fuse capture has taken place, cfg_ready is 0, cap_reduced is 0, spare_hit is 0 and phys_row equals {1'b0, acc_row}.
- R2: At the first rising clock edge with rst low, the fuse inputs are captured and cfg_ready becomes 1. It stays 1 until the next reset.
- R3: After capture, any change on the fuse inputs has no effect on phys_row, spare_hit or cap_reduced.
- R4: If no valid spare entry matches the folded row, spare_hit is 0 and phys_row is {1'b0, folded row}. The folded row equals acc_row in full-capacity mode.
- R5: If valid spare entry k matches the folded row, spare_hit is 1 and phys_row equals 2^ROW_W + k.
- R6: A spare entry whose valid bit is 0 never matches, whatever its row index holds.
- R7: If several valid entries match the same row, the entry with the lowest index is selected.
- R8: With the half-off fuse set, bit ROW_W-1 of the folded row equals the kept-half bit for every access, and cap_reduced is 1.
- R9: In half-capacity mode, spare entries are compared with the folded row. An entry whose row lies in the disabled half never matches.
- R10: phys_row and spare_hit follow acc_row in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fuse_spare_vld | input | NUM_SPARE | Valid bit for each spare entry |
| fuse_spare_row | input | NUM_SPARE*ROW_W | Defective row index per entry; entry k occupies bits [k*ROW_W +: ROW_W] |
| fuse_half_off | input | 1 | 1 runs the array at half capacity |
| fuse_half_keep | input | 1 | Value forced onto the top row bit in half-capacity mode |
| acc_row | input | ROW_W | Logical row of the current access |
| cfg_ready | output | 1 | Fuse configuration has been captured |
| phys_row | output | ROW_W+1 | Physical row: data row, or 2^ROW_W + spare index |
| spare_hit | output | 1 | The access is steered to a spare row |
| cap_reduced | output | 1 | Array is running at half capacity |

## Verification
Folding and spare substitution can act on the same access. This happens when half-capacity mode is on and a spare entry names a row in the kept half. The bench provokes it with access rows whose top bit belongs to the disabled half and whose lower bits equal the spare entry's row, so the spare can only be reached after folding. It also uses the opposite case, a spare entry in the disabled half whose lower bits equal those of the access. The bench judges the first case by requiring a spare hit together with cap_reduced, and the second by requiring a plain folded data row with no hit.

// File: rtl/cache_row_remap_pkg.sv
package cache_row_remap_pkg;

    parameter int ROW_W       = 6;
    parameter int NUM_SPARE   = 2;
    parameter int SPARE_IDX_W = (NUM_SPARE > 1) ? $clog2(NUM_SPARE) : 1;
    parameter int PHYS_W      = ROW_W + 1;

    typedef logic [ROW_W-1:0]       row_t;
    typedef logic [PHYS_W-1:0]      phys_t;
    typedef logic [SPARE_IDX_W-1:0] spare_idx_t;

    typedef enum logic {
        CAP_FULL = 1'b0,
        CAP_HALF = 1'b1
    } cap_mode_e;

    typedef struct packed {
        logic [NUM_SPARE-1:0] vld;
        row_t [NUM_SPARE-1:0] row;
        cap_mode_e            mode;
        logic                 keep;
    } fuse_cfg_t;

    typedef struct packed {
        logic       hit;
        spare_idx_t idx;
    } spare_sel_t;

    function automatic row_t fold_row(row_t r, cap_mode_e m, logic keep);
        row_t f;
        f = r;
        if (m == CAP_HALF) f[ROW_W-1] = keep;
        return f;
    endfunction

    function automatic phys_t make_phys(row_t r, spare_sel_t s);
        if (s.hit) return {1'b1, ROW_W'(s.idx)};
        return {1'b0, r};
    endfunction

endpackage

// File: rtl/cache_row_remap_fuse_hold.sv
module cache_row_remap_fuse_hold
    import cache_row_remap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fuse_cfg_t fuse_in,
    output fuse_cfg_t cfg,
    output logic      ready
);
    fuse_cfg_t cfg_q;
    logic      ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            ready_q <= 1'b0;
        end else if (!ready_q) begin
            cfg_q   <= fuse_in;
            ready_q <= 1'b1;
        end
    end

    assign cfg   = cfg_q;
    assign ready = ready_q;
endmodule

// File: rtl/cache_row_remap_match.sv
module cache_row_remap_match
    import cache_row_remap_pkg::*;
(
    input  fuse_cfg_t  cfg,
    input  row_t       row,
    output spare_sel_t sel
);
    logic [NUM_SPARE-1:0] hits;

    for (genvar k = 0; k < NUM_SPARE; k++) begin : g_cmp
        assign hits[k] = cfg.vld[k] && (cfg.row[k] == row);
    end

    always_comb begin
        sel = '0;
        for (int k = NUM_SPARE - 1; k >= 0; k--) begin
            if (hits[k]) begin
                sel.hit = 1'b1;
                sel.idx = SPARE_IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/cache_row_remap.sv
module cache_row_remap
    import cache_row_remap_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SPARE-1:0]       fuse_spare_vld,
    input  logic [NUM_SPARE*ROW_W-1:0] fuse_spare_row,
    input  logic                       fuse_half_off,
    input  logic                       fuse_half_keep,
    input  logic [ROW_W-1:0]           acc_row,
    output logic                       cfg_ready,
    output logic [PHYS_W-1:0]          phys_row,
    output logic                       spare_hit,
    output logic                       cap_reduced
);
    fuse_cfg_t  fuse_in;
    fuse_cfg_t  cfg;
    row_t       folded;
    spare_sel_t sel;

    always_comb begin
        fuse_in      = '0;
        fuse_in.vld  = fuse_spare_vld;
        for (int k = 0; k < NUM_SPARE; k++)
            fuse_in.row[k] = fuse_spare_row[k*ROW_W +: ROW_W];
        fuse_in.mode = fuse_half_off ? CAP_HALF : CAP_FULL;
        fuse_in.keep = fuse_half_keep;
    end

    cache_row_remap_fuse_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .fuse_in (fuse_in),
        .cfg     (cfg),
        .ready   (cfg_ready)
    );

    assign folded = fold_row(acc_row, cfg.mode, cfg.keep);

    cache_row_remap_match u_match (
        .cfg (cfg),
        .row (folded),
        .sel (sel)
    );

    assign phys_row    = make_phys(folded, sel);
    assign spare_hit   = sel.hit;
    assign cap_reduced = (cfg.mode == CAP_HALF);
endmodule

// File: rtl/cache_row_remap_chk.sv
module cache_row_remap_chk
    import cache_row_remap_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ROW_W-1:0]  acc_row,
    input logic              cfg_ready,
    input logic [PHYS_W-1:0] phys_row,
    input logic              spare_hit,
    input logic              cap_reduced
);
    localparam logic [ROW_W-1:0] SPARE_LIM = ROW_W'(NUM_SPARE);

    // R1: pass-through before capture
    p_idle_passthru_r1: assert property (@(posedge clk) disable iff (rst)
        !cfg_ready |-> (phys_row == {1'b0, acc_row}) && !spare_hit && !cap_reduced);

    // R2: ready stays up once set
    p_ready_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_ready |=> cfg_ready);

    // R3: mode frozen after capture
    p_mode_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_ready |=> $stable(cap_reduced));

    // R4: a miss in full mode keeps the row unchanged
    p_miss_identity_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_ready && !cap_reduced && !spare_hit) |-> (phys_row == {1'b0, acc_row}));

    // R5: a hit points into the spare region
    p_hit_region_r5: assert property (@(posedge clk) disable iff (rst)
        spare_hit |-> phys_row[ROW_W] && (phys_row[ROW_W-1:0] < SPARE_LIM));

    // R4: a miss never points into the spare region
    p_miss_region_r4: assert property (@(posedge clk) disable iff (rst)
        !spare_hit |-> !phys_row[ROW_W]);

    // R8: the folded top bit is constant across half-mode misses
    p_fold_top_r8: assert property (@(posedge clk) disable iff (rst)
        (cap_reduced && !spare_hit && $past(cap_reduced && !spare_hit))
        |-> (phys_row[ROW_W-1] == $past(phys_row[ROW_W-1])));

    // R8: in half mode the lower bits of a miss follow the access
    p_fold_low_r8: assert property (@(posedge clk) disable iff (rst)
        (cap_reduced && !spare_hit) |-> (phys_row[ROW_W-2:0] == acc_row[ROW_W-2:0]));
endmodule

bind cache_row_remap cache_row_remap_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_row     (acc_row),
    .cfg_ready   (cfg_ready),
    .phys_row    (phys_row),
    .spare_hit   (spare_hit),
    .cap_reduced (cap_reduced)
);

// File: tb/cache_row_remap_test.sv
module cache_row_remap_test;
    import cache_row_remap_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SPARE_BASE = 1 << ROW_W;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic [NUM_SPARE-1:0]       fuse_spare_vld = '0;
    logic [NUM_SPARE*ROW_W-1:0] fuse_spare_row = '0;
    logic                       fuse_half_off = 1'b0;
    logic                       fuse_half_keep = 1'b0;
    logic [ROW_W-1:0]           acc_row = '0;
    logic                       cfg_ready;
    logic [PHYS_W-1:0]          phys_row;
    logic                       spare_hit;
    logic                       cap_reduced;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_row_remap uut (
        .clk            (clk),
        .rst            (rst),
        .fuse_spare_vld (fuse_spare_vld),
        .fuse_spare_row (fuse_spare_row),
        .fuse_half_off  (fuse_half_off),
        .fuse_half_keep (fuse_half_keep),
        .acc_row        (acc_row),
        .cfg_ready      (cfg_ready),
        .phys_row       (phys_row),
        .spare_hit      (spare_hit),
        .cap_reduced    (cap_reduced)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic access(input string tag, input int row, input int exp_phys, input int exp_hit);
        @(negedge clk);
        acc_row = ROW_W'(row);
        #1;
        chk({tag, " phys"}, int'(phys_row), exp_phys);
        chk({tag, " hit"}, int'(spare_hit), exp_hit);
    endtask

    task automatic load_cfg(input logic [1:0] vld, input int r0, input int r1,
                            input logic off, input logic keep);
        @(negedge clk);
        rst            = 1'b1;
        fuse_spare_vld = vld;
        fuse_spare_row = {ROW_W'(r1), ROW_W'(r0)};
        fuse_half_off  = off;
        fuse_half_keep = keep;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 ready after capture", int'(cfg_ready), 1);
        chk("R8 cap_reduced", int'(cap_reduced), int'(off));
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst            = 1'b1;
        fuse_spare_vld = 2'b01;
        fuse_spare_row = {ROW_W'(0), ROW_W'(5)};
        fuse_half_off  = 1'b1;
        acc_row        = ROW_W'(37);
        @(negedge clk);
        #1;
        chk("R1 ready in reset", int'(cfg_ready), 0);
        chk("R1 passthru in reset", int'(phys_row), 37);
        chk("R1 no hit in reset", int'(spare_hit), 0);
        chk("R1 cap in reset", int'(cap_reduced), 0);
        acc_row = ROW_W'(5);
        #1;
        chk("R1 no steering before capture", int'(phys_row), 5);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 not ready before first edge", int'(cfg_ready), 0);
        @(negedge clk);
        chk("R2 ready one edge after release", int'(cfg_ready), 1);
    endtask

    task automatic t_basic();
        load_cfg(2'b11, 5, 40, 1'b0, 1'b0);
        access("R4 miss row 6", 6, 6, 0);
        access("R4 miss row 63", 63, 63, 0);
        access("R5 spare0 row 5", 5, SPARE_BASE + 0, 1);
        access("R5 spare1 row 40", 40, SPARE_BASE + 1, 1);
        access("R4 miss row 0", 0, 0, 0);
    endtask

    task automatic t_comb_path();
        @(negedge clk);
        acc_row = ROW_W'(40);
        #1;
        chk("R10 same-cycle hit", int'(phys_row), SPARE_BASE + 1);
        acc_row = ROW_W'(41);
        #1;
        chk("R10 same-cycle miss", int'(phys_row), 41);
    endtask

    task automatic t_invalid();
        load_cfg(2'b10, 7, 9, 1'b0, 1'b0);
        access("R6 invalid entry ignored", 7, 7, 0);
        access("R5 valid entry 1", 9, SPARE_BASE + 1, 1);
    endtask

    task automatic t_priority();
        load_cfg(2'b11, 12, 12, 1'b0, 1'b0);
        access("R7 lower spare wins", 12, SPARE_BASE + 0, 1);
    endtask

    task automatic t_half_low();
        load_cfg(2'b01, 3, 0, 1'b1, 1'b0);
        access("R8 fold to low half", 36, 4, 0);
        access("R9 fold then spare", 35, SPARE_BASE + 0, 1);
        access("R8 low half unchanged", 20, 20, 0);
    endtask

    task automatic t_half_high();
        load_cfg(2'b11, 3, 40, 1'b1, 1'b1);
        access("R9 entry in dropped half", 3, 35, 0);
        access("R9 fold reaches spare1", 8, SPARE_BASE + 1, 1);
        access("R8 fold to high half", 17, 49, 0);
    endtask

    task automatic t_hold();
        load_cfg(2'b01, 5, 0, 1'b0, 1'b0);
        @(negedge clk);
        fuse_spare_vld = 2'b10;
        fuse_spare_row = {ROW_W'(22), ROW_W'(0)};
        fuse_half_off  = 1'b1;
        fuse_half_keep = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 cap unchanged", int'(cap_reduced), 0);
        access("R3 old entry kept", 5, SPARE_BASE + 0, 1);
        access("R3 new entry ignored", 22, 22, 0);
        access("R3 no fold applied", 2, 2, 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        t_reset_state();
        t_basic();
        t_comb_path();
        t_invalid();
        t_priority();
        t_half_low();
        t_half_high();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule